// File: doc/BRIEF.md
# Sticky Write-Protect and Expiration Controller

This block sits beside the three counters of a small timekeeping device: a real-time clock, an interval timer and a cycle counter. It decides whether each host write to a counter value, a counter alarm or the shared control register may take effect. It owns the control register, because several of its fields change meaning once protection is active. A locked field either ignores the write, accepts only a 0-to-1 change, or is held at 0.

The three protect bits are committed only through a guarded sequence. The host must issue the same scratchpad-copy request for the protect bits several times in a row, three times by default. After the first accepted copy an authorization flag is raised, and each later copy must present that flag. Once any protect bit is committed, the protect bits are frozen for good. Any bit that was left clear can never be set afterwards.

When a protected counter's alarm fires, a sticky expiration flag is set and the memory-command permission outputs narrow. Which commands stay open depends on the read-only control bit. The counters, the scratchpad storage and the serial bus are outside this block.

Top module: `wp_guard`

## Requirements
- R1: The protect bits `prot_o` (bit 0 real-time clock, bit 1 interval timer, bit 2 cycle counter) take the value of `cp_bits_i` only at the clock edge that samples the third consecutive accepted copy request. After the first or second request they are unchanged.
- R2: The first accepted copy request raises `auth_flag_o`. A second or third request must carry `cp_auth_i`=1 and the same `cp_bits_i`; otherwise the sequence restarts, `auth_flag_o` clears and that request does not count. The flag clears again at commit.
- R3: A copy request with protect data different from the previous one restarts the sequence. So does a pulse on `mem_cmd_i` (any other memory command) between copies. After a restart, three new matching requests are needed.
- R4: Once any protect bit is 1, `prot_o` never changes again and further copy requests have no effect; `auth_flag_o` stays 0.
- R5: `wr_sel_i` selects the target: 0/1 real-time value/alarm, 2/3 interval value/alarm, 4/5 cycle value/alarm, 6 control register, 7 unused. One cycle after a write, `wr_ok_o` pulses if it is allowed. `wr_reject_o` pulses instead if it targets a counter or alarm whose protect bit is set, or targets 7, or tries to change a locked control field.
- R6: Control bit 4 (read-only, `ctrl_o[4]`) ignores writes while any protect bit is set.
- R7: Control bit 0 (oscillator enable) is write-one-only while any protect bit is set: it can be set but not cleared.
- R8: While the interval protect bit is set, control bit 2 (auto/manual) ignores writes. Control bit 1 (run) reads 0 from the second clock edge after the commit onward, and writes of 1 to it are rejected.
- R9: While the cycle protect bit is set, control bit 3 (delay select) ignores writes. With that protect bit clear, it follows writes.
- R10: `expired_o` rises at the clock edge that samples an `alarm_i` bit whose protect bit is set, and stays 1 until reset. An alarm of an unprotected counter has no effect.
- R11: Before expiration, `perm_rd_scratch_o`, `perm_rd_mem_o` and `perm_other_o` are all 1. After expiration with `ctrl_o[4]`=1, only the two read permissions are 1. After expiration with `ctrl_o[4]`=0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_valid_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Write target select |
| wr_data_i | input | 5 | Control register data (used when target is 6) |
| cp_valid_i | input | 1 | Scratchpad copy request aimed at the protect bits |
| cp_bits_i | input | 3 | Protect-bit data carried by the copy request |
| cp_auth_i | input | 1 | Authorization-flag bit presented in the copy pattern |
| mem_cmd_i | input | 1 | Any other memory command was issued |
| alarm_i | input | 3 | Alarm events from the three counters |
| prot_o | output | 3 | Committed protect bits |
| auth_flag_o | output | 1 | Authorization-accepted flag |
| ctrl_o | output | 5 | Control register: osc, run, auto, delay select, read-only |
| wr_ok_o | output | 1 | Write accepted pulse |
| wr_reject_o | output | 1 | Write rejected pulse |
| expired_o | output | 1 | Sticky expiration flag |
| perm_rd_scratch_o | output | 1 | Read-scratchpad command permitted |
| perm_rd_mem_o | output | 1 | Read-memory command permitted |
| perm_other_o | output | 1 | All other memory commands permitted |

## Verification
The embedded assertions watch, on every cycle, the properties that hold across time regardless of stimulus. These are the permanence of committed protect bits, the rule that a commit only follows a full authorized count, and the frozen read-only bit and non-falling oscillator bit under protection. They also cover the held-low run bit, the stickiness and cause of expiration, and the exclusivity of the write pulses. Only the bench scenarios can show that the control register takes the exact value the rules dictate after arbitrary writes. The same holds for restarts after mismatched data, a missing flag or an intervening command needing exactly three fresh requests, and for the permission pattern splitting on the read-only bit.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
   localparam int NUM_CNT = 3;
   localparam int CTRL_W  = 5;
   localparam int SEL_W   = 3;
   localparam int IDX_RTC = 0;
   localparam int IDX_IVL = 1;
   localparam int IDX_CYC = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_RTC_VAL = 3'd0,
      SEL_RTC_ALM = 3'd1,
      SEL_IVL_VAL = 3'd2,
      SEL_IVL_ALM = 3'd3,
      SEL_CYC_VAL = 3'd4,
      SEL_CYC_ALM = 3'd5,
      SEL_CTRL    = 3'd6,
      SEL_NONE    = 3'd7
   } wsel_e;

   typedef struct packed {
      logic ro;
      logic dsel;
      logic auto_m;
      logic run;
      logic osc;
   } ctrl_t;
endpackage

// File: rtl/wp_copy_seq.sv
module wp_copy_seq #(
   parameter int NBITS       = 3,
   parameter int COPY_NEEDED = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cp_valid_i,
   input  logic [NBITS-1:0] cp_bits_i,
   input  logic             cp_auth_i,
   input  logic             mem_cmd_i,
   output logic [NBITS-1:0] prot_o,
   output logic             auth_flag_o
);
   localparam int CW = $clog2(COPY_NEEDED + 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(COPY_NEEDED - 1);

   if (COPY_NEEDED < 2) begin : g_bad_count
      $error("COPY_NEEDED must be at least 2");
   end
   if (NBITS < 1) begin : g_bad_bits
      $error("NBITS must be positive");
   end

   logic [CW-1:0]    cnt_q;
   logic [NBITS-1:0] last_q;
   logic [NBITS-1:0] prot_q;
   logic             acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= '0;
         prot_q <= '0;
         acc_q  <= 1'b0;
      end else if (prot_q == '0) begin
         if (mem_cmd_i) begin
            cnt_q <= '0;
            acc_q <= 1'b0;
         end else if (cp_valid_i) begin
            if (cnt_q == '0) begin
               cnt_q  <= CW'(1);
               last_q <= cp_bits_i;
               acc_q  <= 1'b1;
            end else if (cp_bits_i == last_q && cp_auth_i) begin
               if (cnt_q == LAST_CNT) begin
                  prot_q <= cp_bits_i;
                  cnt_q  <= '0;
                  acc_q  <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end else begin
               cnt_q <= '0;
               acc_q <= 1'b0;
            end
         end
      end
   end

   assign prot_o      = prot_q;
   assign auth_flag_o = acc_q;

   assert_prot_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q != '0) |=> $stable(prot_q));
   assert_commit_after_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(prot_q) == '0 && prot_q != '0) |->
      $past(cp_valid_i && cp_auth_i && cnt_q == LAST_CNT));
   assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_CNT);
   assert_flag_with_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> acc_q);
endmodule

// File: rtl/wp_reg_gate.sv
module wp_reg_gate
   import wp_guard_pkg::*;
#(
   parameter int NBITS      = 3,
   parameter bit FORCE_STOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid_i,
   input  logic [SEL_W-1:0]  wr_sel_i,
   input  logic [CTRL_W-1:0] wr_data_i,
   input  logic [NBITS-1:0]  prot_i,
   output ctrl_t             ctrl_o,
   output logic              wr_ok_o,
   output logic              wr_reject_o
);
   localparam int EXT_W = 1 << (SEL_W - 1);

   if (NBITS != NUM_CNT) begin : g_bad_bits
      $error("gate expects one protect bit per counter");
   end

   ctrl_t            ctrl_q, ctrl_d, wr_val;
   logic [EXT_W-1:0] prot_ext;
   logic [SEL_W-2:0] cnt_idx;
   logic             any_lock, rej, is_cnt, is_ctrl;
   logic             ok_q, rej_q;

   always_comb begin
      prot_ext = '0;
      prot_ext[NBITS-1:0] = prot_i;
   end

   assign any_lock = |prot_i;
   assign cnt_idx  = wr_sel_i[SEL_W-1:1];
   assign is_cnt   = wr_sel_i < SEL_CTRL;
   assign is_ctrl  = wr_sel_i == SEL_CTRL;
   assign wr_val   = ctrl_t'(wr_data_i);

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_valid_i && is_ctrl) begin
         ctrl_d.osc    = any_lock ? (ctrl_q.osc | wr_val.osc) : wr_val.osc;
         ctrl_d.run    = wr_val.run;
         ctrl_d.auto_m = prot_i[IDX_IVL] ? ctrl_q.auto_m : wr_val.auto_m;
         ctrl_d.dsel   = prot_i[IDX_CYC] ? ctrl_q.dsel   : wr_val.dsel;
         ctrl_d.ro     = any_lock        ? ctrl_q.ro     : wr_val.ro;
      end
      if (FORCE_STOP && prot_i[IDX_IVL]) begin
         ctrl_d.run = 1'b0;
      end
   end

   always_comb begin
      if (is_cnt)       rej = prot_ext[cnt_idx];
      else if (is_ctrl) rej = (ctrl_d != wr_val);
      else              rej = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ok_q   <= 1'b0;
         rej_q  <= 1'b0;
      end else begin
         ctrl_q <= ctrl_d;
         ok_q   <= wr_valid_i && !rej;
         rej_q  <= wr_valid_i && rej;
      end
   end

   assign ctrl_o      = ctrl_q;
   assign wr_ok_o     = ok_q;
   assign wr_reject_o = rej_q;

   assert_ro_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (any_lock && $past(any_lock)) |-> $stable(ctrl_q.ro));
   assert_osc_no_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (any_lock && $past(any_lock)) |-> !$fell(ctrl_q.osc));
   assert_auto_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_i[IDX_IVL] && $past(prot_i[IDX_IVL])) |-> $stable(ctrl_q.auto_m));
   assert_dsel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_i[IDX_CYC] && $past(prot_i[IDX_CYC])) |-> $stable(ctrl_q.dsel));
   assert_pulse_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok_q && rej_q));
   assert_locked_counter_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_valid_i && is_cnt && prot_ext[cnt_idx]) |-> rej_q);

   if (FORCE_STOP) begin : g_stop_chk
      assert_run_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (prot_i[IDX_IVL] && $past(prot_i[IDX_IVL])) |-> !ctrl_q.run);
   end
endmodule

// File: rtl/wp_expiry.sv
module wp_expiry #(
   parameter int NBITS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] prot_i,
   input  logic [NBITS-1:0] alarm_i,
   input  logic             ro_i,
   output logic             expired_o,
   output logic             perm_rd_scratch_o,
   output logic             perm_rd_mem_o,
   output logic             perm_other_o
);
   logic [NBITS-1:0] hit;
   logic             expired_q;

   for (genvar i = 0; i < NBITS; i++) begin : g_hit
      assign hit[i] = prot_i[i] & alarm_i[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) expired_q <= 1'b0;
      else if (|hit) expired_q <= 1'b1;
   end

   always_comb begin
      perm_rd_scratch_o = !expired_q || ro_i;
      perm_rd_mem_o     = !expired_q || ro_i;
      perm_other_o      = !expired_q;
   end

   assign expired_o = expired_q;

   assert_expiry_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      expired_q |=> expired_q);
   assert_expiry_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired_q) |-> $past(|(prot_i & alarm_i)));
endmodule

// File: rtl/wp_guard.sv
module wp_guard
   import wp_guard_pkg::*;
#(
   parameter int COPY_NEEDED = 3,
   parameter bit FORCE_STOP  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_valid_i,
   input  logic [2:0]  wr_sel_i,
   input  logic [4:0]  wr_data_i,
   input  logic        cp_valid_i,
   input  logic [2:0]  cp_bits_i,
   input  logic        cp_auth_i,
   input  logic        mem_cmd_i,
   input  logic [2:0]  alarm_i,
   output logic [2:0]  prot_o,
   output logic        auth_flag_o,
   output logic [4:0]  ctrl_o,
   output logic        wr_ok_o,
   output logic        wr_reject_o,
   output logic        expired_o,
   output logic        perm_rd_scratch_o,
   output logic        perm_rd_mem_o,
   output logic        perm_other_o
);
   logic [NUM_CNT-1:0] prot;
   ctrl_t              ctrl;

   wp_copy_seq #(.NBITS(NUM_CNT), .COPY_NEEDED(COPY_NEEDED)) i_seq (
      .clk(clk), .rst_n(rst_n),
      .cp_valid_i(cp_valid_i), .cp_bits_i(cp_bits_i), .cp_auth_i(cp_auth_i),
      .mem_cmd_i(mem_cmd_i),
      .prot_o(prot), .auth_flag_o(auth_flag_o)
   );

   wp_reg_gate #(.NBITS(NUM_CNT), .FORCE_STOP(FORCE_STOP)) i_gate (
      .clk(clk), .rst_n(rst_n),
      .wr_valid_i(wr_valid_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .prot_i(prot),
      .ctrl_o(ctrl), .wr_ok_o(wr_ok_o), .wr_reject_o(wr_reject_o)
   );

   wp_expiry #(.NBITS(NUM_CNT)) i_exp (
      .clk(clk), .rst_n(rst_n),
      .prot_i(prot), .alarm_i(alarm_i), .ro_i(ctrl.ro),
      .expired_o(expired_o),
      .perm_rd_scratch_o(perm_rd_scratch_o),
      .perm_rd_mem_o(perm_rd_mem_o),
      .perm_other_o(perm_other_o)
   );

   assign prot_o = prot;
   assign ctrl_o = ctrl;
endmodule

// File: tb/test_wp_guard.sv
module test_wp_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid_i = 1'b0;
   logic [2:0] wr_sel_i = '0;
   logic [4:0] wr_data_i = '0;
   logic       cp_valid_i = 1'b0;
   logic [2:0] cp_bits_i = '0;
   logic       cp_auth_i = 1'b0;
   logic       mem_cmd_i = 1'b0;
   logic [2:0] alarm_i = '0;
   logic [2:0] prot_o;
   logic       auth_flag_o;
   logic [4:0] ctrl_o;
   logic       wr_ok_o, wr_reject_o, expired_o;
   logic       perm_rd_scratch_o, perm_rd_mem_o, perm_other_o;

   int n_checks = 0;
   int n_fail = 0;
   logic [4:0] ec;

   wp_guard i_wp_guard (.*);

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] ctrl_model(input logic [4:0] cur, input logic [4:0] d,
                                             input logic [2:0] p);
      logic [4:0] r;
      r = d;
      if (|p) begin
         r[0] = cur[0] | d[0];
         r[4] = cur[4];
      end
      if (p[1]) begin
         r[2] = cur[2];
         r[1] = 1'b0;
      end
      if (p[2]) r[3] = cur[3];
      return r;
   endfunction

   function automatic logic [2:0] perm_model(input logic exp, input logic ro);
      if (!exp) return 3'b111;
      return ro ? 3'b110 : 3'b000;
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      ec = '0;
   endtask

   task automatic do_wr(input logic [2:0] s, input logic [4:0] d);
      @(negedge clk); wr_valid_i = 1'b1; wr_sel_i = s; wr_data_i = d;
      @(negedge clk); wr_valid_i = 1'b0;
   endtask

   task automatic do_cp(input logic [2:0] b, input logic a);
      @(negedge clk); cp_valid_i = 1'b1; cp_bits_i = b; cp_auth_i = a;
      @(negedge clk); cp_valid_i = 1'b0;
   endtask

   task automatic do_mem();
      @(negedge clk); mem_cmd_i = 1'b1;
      @(negedge clk); mem_cmd_i = 1'b0;
   endtask

   task automatic do_alarm(input logic [2:0] a);
      @(negedge clk); alarm_i = a;
      @(negedge clk); alarm_i = '0;
   endtask

   task automatic commit3(input logic [2:0] b);
      do_cp(b, 1'b0); do_cp(b, 1'b1); do_cp(b, 1'b1);
   endtask

   function automatic logic [2:0] perms();
      return {perm_rd_scratch_o, perm_rd_mem_o, perm_other_o};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1993));
      do_reset();
      chk("R1 reset prot", prot_o, 0);
      chk("R2 reset flag", auth_flag_o, 0);
      chk("R5 reset ctrl", ctrl_o, 0);
      chk("R10 reset expired", expired_o, 0);
      chk("R11 reset perms", perms(), 3'b111);

      for (int i = 0; i < 16; i++) begin
         logic [2:0] s;
         logic [4:0] d;
         s = 3'($urandom % 8);
         d = 5'($urandom);
         do_wr(s, d);
         if (s == 3'd6) ec = d;
         chk("R5 unprotected ctrl", ctrl_o, ec);
         chk("R5 unprotected ok", wr_ok_o, s != 3'd7);
         chk("R5 unprotected reject", wr_reject_o, s == 3'd7);
      end

      do_wr(3'd6, 5'b00111); ec = 5'b00111;
      do_cp(3'b010, 1'b0);
      chk("R2 flag after first", auth_flag_o, 1);
      chk("R1 no commit after first", prot_o, 0);
      do_cp(3'b010, 1'b1);
      chk("R1 no commit after second", prot_o, 0);
      do_cp(3'b010, 1'b1);
      chk("R1 commit on third", prot_o, 3'b010);
      chk("R2 flag cleared at commit", auth_flag_o, 0);
      @(negedge clk);
      ec = 5'b00101;
      chk("R8 run forced low", ctrl_o, ec);

      do_wr(3'd6, ec | 5'b00001); ec = ec | 5'b00001;
      do_wr(3'd6, ec & 5'b11110);
      chk("R7 osc not cleared", ctrl_o[0], 1);
      chk("R7 clear attempt rejected", wr_reject_o, 1);
      do_wr(3'd6, ec | 5'b10000);
      chk("R6 ro locked", ctrl_o[4], 0);
      do_wr(3'd6, ec | 5'b00010);
      chk("R8 run write rejected", wr_reject_o, 1);
      chk("R8 run stays low", ctrl_o[1], 0);
      do_wr(3'd6, (ec & 5'b11011) | 5'b01000);
      chk("R8 auto locked", ctrl_o[2], 1);
      chk("R9 dsel free when cycle unprotected", ctrl_o[3], 1);
      ec = ctrl_o;

      for (int i = 0; i < 12; i++) begin
         logic [4:0] d, e;
         d = 5'($urandom);
         e = ctrl_model(ec, d, 3'b010);
         do_wr(3'd6, d);
         chk("R6/R7/R8 ctrl model", ctrl_o, e);
         chk("R5 ctrl reject model", wr_reject_o, e != d);
         ec = e;
      end

      do_wr(3'd2, 5'd0);
      chk("R5 interval value rejected", wr_reject_o, 1);
      do_wr(3'd3, 5'd0);
      chk("R5 interval alarm rejected", wr_reject_o, 1);
      do_wr(3'd0, 5'd0);
      chk("R5 rtc value allowed", wr_ok_o, 1);
      do_wr(3'd5, 5'd0);
      chk("R5 cycle alarm allowed", wr_ok_o, 1);

      commit3(3'b111);
      chk("R4 prot frozen", prot_o, 3'b010);
      chk("R4 flag stays low", auth_flag_o, 0);

      do_alarm(3'b101);
      chk("R10 unprotected alarm ignored", expired_o, 0);
      chk("R11 perms before expiry", perms(), 3'b111);
      do_alarm(3'b010);
      chk("R10 expired on protected alarm", expired_o, 1);
      chk("R11 perms after expiry", perms(), perm_model(1'b1, ec[4]));
      repeat (3) @(negedge clk);
      chk("R10 expiry sticky", expired_o, 1);

      do_reset();
      do_cp(3'b100, 1'b0);
      do_cp(3'b100, 1'b0);
      chk("R2 missing flag restarts", auth_flag_o, 0);
      do_cp(3'b100, 1'b1);
      do_cp(3'b100, 1'b1);
      chk("R2 restart needs three", prot_o, 0);
      do_cp(3'b100, 1'b1);
      chk("R2 commit after restart", prot_o, 3'b100);

      do_reset();
      do_cp(3'b001, 1'b0);
      do_cp(3'b001, 1'b1);
      do_cp(3'b011, 1'b1);
      chk("R3 data change restarts", auth_flag_o, 0);
      chk("R3 no commit on mismatch", prot_o, 0);
      do_cp(3'b011, 1'b0);
      do_cp(3'b011, 1'b1);
      do_mem();
      chk("R3 memory command restarts", auth_flag_o, 0);
      do_cp(3'b011, 1'b1);
      do_cp(3'b011, 1'b1);
      chk("R3 no commit after two", prot_o, 0);
      do_cp(3'b011, 1'b1);
      chk("R3 commit after fresh three", prot_o, 3'b011);

      do_reset();
      do_wr(3'd6, 5'b11001); ec = 5'b11001;
      commit3(3'b100);
      chk("R1 cycle commit", prot_o, 3'b100);
      do_wr(3'd6, 5'b00000);
      chk("R9 dsel locked", ctrl_o, ctrl_model(ec, 5'b00000, 3'b100));
      chk("R9 locked change rejected", wr_reject_o, 1);
      do_wr(3'd4, 5'd0);
      chk("R5 cycle value rejected", wr_reject_o, 1);
      do_wr(3'd2, 5'd0);
      chk("R5 interval value allowed", wr_ok_o, 1);
      do_alarm(3'b100);
      chk("R10 cycle alarm expires", expired_o, 1);
      chk("R11 read-only perms", perms(), 3'b110);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule